// File: doc/BRIEF.md
# Maskable Interrupt and DMA Request Router

This block collects thirteen event sources from a card-interface controller into a sticky request register and turns them into one processor interrupt line. Each source has a mask bit; a set mask bit silences that source. When the control register selects DMA operation, the two FIFO service requests are taken away from the processor interrupt and drive a receive and a transmit DMA request line directly. Outside DMA operation those two lines stay low.

The block also owns the card clock's start/stop control. Starting the clock raises the clock-enable status and withdraws the clock-off request. Stopping it does the reverse. A start that finds a command pending while the stop-transfer control bit is clear emits a one-cycle launch pulse for that command. Software reaches everything through a small word-addressed register bus. Writes take effect at the clock edge, reads are combinational, and every output is a direct function of registered state, so a write is visible on the outputs in the cycle after its edge. There is no data stream here, so no pin carries a valid/ready handshake.

Address 0 is clock control. On a write, bit 1 starts the clock and bit 0 stops it; a read returns the clock-enable status in bit 8. Address 1 is the control register: bit 7 selects DMA and bit 10 is stop-transfer. Address 2 is the mask. Address 3 is the request register; writing it clears every request bit written as 1.

Top module: `irq_dma_router`

## Requirements
- R1: After reset, the request register, mask and control register read 0, clock-enable is 0, and `cpu_irq`, `rx_dma_req`, `tx_dma_req` and `cmd_launch` are low.
- R2: A 1 on `evt_set[i]` at a clock edge sets request bit i, readable at address 3 from the next cycle. The bit positions are: 0 data done, 1 programming done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: `cpu_irq` is high exactly when some request bit is set whose effective mask bit is 0.
- R4: A mask write at address 2 keeps only data bits 12:0, and bits above 12 read back as 0.
- R5: With control bit 7 set, request bits 5 and 6 never raise `cpu_irq`; `rx_dma_req` follows request bit 5 and `tx_dma_req` follows request bit 6. The control register stores only bits 7 and 10, and all other bits read back as 0.
- R6: With control bit 7 clear, `rx_dma_req` and `tx_dma_req` are low whatever the request bits hold.
- R7: A write at address 3 clears each request bit whose data bit is 1 and leaves bits written as 0 unchanged.
- R8: If a request bit is set by an event and cleared in the same cycle, it ends up set.
- R9: A write at address 0 with bit 1 set and bit 0 clear sets clock-enable (read at address 0 as bit 8) and clears request bit 4.
- R10: A write at address 0 with bit 0 set clears clock-enable and sets request bit 4. This holds even when bit 1 is also set.
- R11: A write at address 0 with bit 1 set, while `cmd_pending` is high and control bit 10 is clear, raises `cmd_launch` for exactly one cycle. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| evt_set | input | SRC_N | Per-source event pulses |
| cmd_pending | input | 1 | A command is waiting for the clock |
| cpu_irq | output | 1 | Processor interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| clk_en | output | 1 | Card clock enable status |
| cmd_launch | output | 1 | One-cycle command launch pulse |

## Verification
The bench builds the block with its default 32-bit data width and 13 sources. This puts data bits above 12 on the bus, so mask truncation and control-register bit filtering can be observed, and it places the stop-transfer bit 10 inside the word. With 13 sources, the card acknowledge source at bit 12 is exercised at the top edge of the mask. The clock-off source shares its bit with the clock control path, so the stop/start interplay with event sets is reachable.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  localparam int SRC_N          = 13;
  localparam int BIT_CLK_OFF    = 4;
  localparam int BIT_RX_REQ     = 5;
  localparam int BIT_TX_REQ     = 6;
  localparam int CTRL_DMA_BIT   = 7;
  localparam int CTRL_STOPX_BIT = 10;
  localparam int STAT_CLKEN_BIT = 8;
  localparam int CLK_STOP_BIT   = 0;
  localparam int CLK_START_BIT  = 1;

  typedef enum logic [1:0] {
    A_CLK  = 2'd0,
    A_CTRL = 2'd1,
    A_MASK = 2'd2,
    A_REQ  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int SRC_N = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] req_o
);
  // Set dominates clear: an event landing with a clear is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= '0;
    else        req_o <= (req_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int SRC_N  = 13,
  parameter int RX_BIT = 5,
  parameter int TX_BIT = 6
) (
  input  logic [SRC_N-1:0] req_i,
  input  logic [SRC_N-1:0] mask_i,
  input  logic             dma_en_i,
  output logic             irq_o,
  output logic             rx_dma_o,
  output logic             tx_dma_o
);
  logic [SRC_N-1:0] eff_mask;

  // FIFO service sources are diverted to DMA when it is selected.
  for (genvar g = 0; g < SRC_N; g++) begin : g_mask
    if (g == RX_BIT || g == TX_BIT) begin : g_fifo
      assign eff_mask[g] = mask_i[g] | dma_en_i;
    end else begin : g_plain
      assign eff_mask[g] = mask_i[g];
    end
  end

  assign irq_o    = |(req_i & ~eff_mask);
  assign rx_dma_o = dma_en_i & req_i[RX_BIT];
  assign tx_dma_o = dma_en_i & req_i[TX_BIT];
endmodule

// File: rtl/clk_ctl.sv
module clk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic cmd_pending_i,
  input  logic stop_xfer_i,
  output logic clk_en_o,
  output logic launch_o,
  output logic off_set_o,
  output logic off_clr_o
);
  // Stop is applied after start, so it wins when both are written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_o <= 1'b0;
      launch_o <= 1'b0;
    end else begin
      if (stop_i)       clk_en_o <= 1'b0;
      else if (start_i) clk_en_o <= 1'b1;
      launch_o <= start_i & cmd_pending_i & ~stop_xfer_i;
    end
  end

  assign off_set_o = stop_i;
  assign off_clr_o = start_i & ~stop_i;
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSRC   = SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_set,
  input  logic              cmd_pending,
  output logic              cpu_irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              clk_en,
  output logic              cmd_launch
);
  reg_addr_e       addr;
  logic            wr_clk, wr_ctrl, wr_mask, wr_req;
  logic [NSRC-1:0] mask_q, req_q, set_vec, clr_vec;
  logic            dma_en_q, stop_xfer_q;
  logic            off_set, off_clr;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_clk  = bus_wr && addr == A_CLK;
  assign wr_ctrl = bus_wr && addr == A_CTRL;
  assign wr_mask = bus_wr && addr == A_MASK;
  assign wr_req  = bus_wr && addr == A_REQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      dma_en_q    <= 1'b0;
      stop_xfer_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[NSRC-1:0];
      if (wr_ctrl) begin
        dma_en_q    <= bus_wdata[CTRL_DMA_BIT];
        stop_xfer_q <= bus_wdata[CTRL_STOPX_BIT];
      end
    end
  end

  clk_ctl u_clk_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (wr_clk & bus_wdata[CLK_START_BIT]),
    .stop_i        (wr_clk & bus_wdata[CLK_STOP_BIT]),
    .cmd_pending_i (cmd_pending),
    .stop_xfer_i   (stop_xfer_q),
    .clk_en_o      (clk_en),
    .launch_o      (cmd_launch),
    .off_set_o     (off_set),
    .off_clr_o     (off_clr)
  );

  always_comb begin
    set_vec = evt_set;
    set_vec[BIT_CLK_OFF] = evt_set[BIT_CLK_OFF] | off_set;
    clr_vec = wr_req ? bus_wdata[NSRC-1:0] : '0;
    clr_vec[BIT_CLK_OFF] = clr_vec[BIT_CLK_OFF] | off_clr;
  end

  irq_req_reg #(.SRC_N(NSRC)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .req_o (req_q)
  );

  irq_route #(.SRC_N(NSRC), .RX_BIT(BIT_RX_REQ), .TX_BIT(BIT_TX_REQ)) u_route (
    .req_i    (req_q),
    .mask_i   (mask_q),
    .dma_en_i (dma_en_q),
    .irq_o    (cpu_irq),
    .rx_dma_o (rx_dma_req),
    .tx_dma_o (tx_dma_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_CLK:  bus_rdata[STAT_CLKEN_BIT] = clk_en;
      A_CTRL: begin
        bus_rdata[CTRL_DMA_BIT]   = dma_en_q;
        bus_rdata[CTRL_STOPX_BIT] = stop_xfer_q;
      end
      A_MASK: bus_rdata[NSRC-1:0] = mask_q;
      A_REQ:  bus_rdata[NSRC-1:0] = req_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
  import irq_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSRC   = SRC_N
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NSRC-1:0]   evt_set,
  input logic [NSRC-1:0]   req,
  input logic [NSRC-1:0]   mask,
  input logic              dma_en,
  input logic              cpu_irq,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic              clk_en,
  input logic              cmd_launch
);
  logic clk_wr;
  assign clk_wr = bus_wr && bus_addr == A_CLK;

  // R2 / R8: every event bit is set on the next cycle, clear or not
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((req & $past(evt_set)) == $past(evt_set)));

  // R3: no unmasked request means no interrupt
  p_quiet_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~mask) == '0) |-> !cpu_irq);

  // R5: DMA lines track the FIFO request bits in DMA mode
  p_dma_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> (rx_dma_req == req[BIT_RX_REQ] && tx_dma_req == req[BIT_TX_REQ]));

  // R6: DMA lines stay low without DMA mode
  p_dma_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (!rx_dma_req && !tx_dma_req));

  // R9: clock start enables and withdraws clock-off
  p_clk_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_wr && bus_wdata[CLK_START_BIT] && !bus_wdata[CLK_STOP_BIT] && !evt_set[BIT_CLK_OFF])
    |=> (clk_en && !req[BIT_CLK_OFF]));

  // R10: clock stop disables and raises clock-off
  p_clk_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_wr && bus_wdata[CLK_STOP_BIT]) |=> (!clk_en && req[BIT_CLK_OFF]));

  // R11: launch is a single-cycle pulse
  p_launch_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |=> !cmd_launch);
endmodule

bind irq_dma_router irq_dma_router_chk #(.DATA_W(DATA_W), .NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .evt_set    (evt_set),
  .req        (req_q),
  .mask       (mask_q),
  .dma_en     (dma_en_q),
  .cpu_irq    (cpu_irq),
  .rx_dma_req (rx_dma_req),
  .tx_dma_req (tx_dma_req),
  .clk_en     (clk_en),
  .cmd_launch (cmd_launch)
);

// File: tb/irq_dma_router_bench.sv
module irq_dma_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [12:0]   evt_set = '0;
  logic          cmd_pending = 1'b0;
  logic          cpu_irq, rx_dma_req, tx_dma_req, clk_en, cmd_launch;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dma_router u_irq_dma_router (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .cmd_pending(cmd_pending), .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req), .clk_en(clk_en), .cmd_launch(cmd_launch)
  );

  typedef struct packed {
    logic [12:0] mask;
    logic        dma;
    logic [12:0] evt;
    logic        irq;
    logic        rx;
    logic        tx;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{13'h0000, 1'b0, 13'h0001, 1'b1, 1'b0, 1'b0},
    '{13'h0001, 1'b0, 13'h0001, 1'b0, 1'b0, 1'b0},
    '{13'h1FFE, 1'b0, 13'h0001, 1'b1, 1'b0, 1'b0},
    '{13'h0000, 1'b0, 13'h0020, 1'b1, 1'b0, 1'b0},
    '{13'h0000, 1'b1, 13'h0020, 1'b0, 1'b1, 1'b0},
    '{13'h0000, 1'b1, 13'h0040, 1'b0, 1'b0, 1'b1},
    '{13'h0000, 1'b1, 13'h0860, 1'b1, 1'b1, 1'b1},
    '{13'h0800, 1'b1, 13'h0860, 1'b0, 1'b1, 1'b1},
    '{13'h0FFF, 1'b0, 13'h1000, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [12:0] e);
    @(negedge clk);
    evt_set = e;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", cpu_irq, 0);
    check("R1 dma", {rx_dma_req, tx_dma_req}, 0);
    check("R1 launch", cmd_launch, 0);
    check("R1 clk_en", clk_en, 0);
    bus_read(2'd3, rd); check("R1 req", rd, 0);
    bus_read(2'd2, rd); check("R1 mask", rd, 0);
    bus_read(2'd1, rd); check("R1 ctrl", rd, 0);

    // Vector table: R2 R3 R5 R6
    foreach (VECS[i]) begin
      bus_write(2'd3, 32'h1FFF);
      bus_write(2'd2, {19'd0, VECS[i].mask});
      bus_write(2'd1, {24'd0, VECS[i].dma, 7'd0});
      pulse_evt(VECS[i].evt);
      check($sformatf("R3 irq vec%0d", i), cpu_irq, VECS[i].irq);
      check($sformatf("R5/R6 rx vec%0d", i), rx_dma_req, VECS[i].rx);
      check($sformatf("R5/R6 tx vec%0d", i), tx_dma_req, VECS[i].tx);
      bus_read(2'd3, rd);
      check($sformatf("R2 req vec%0d", i), rd, {19'd0, VECS[i].evt});
    end

    // R4 mask truncation
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, rd); check("R4 mask readback", rd, 32'h1FFF);
    bus_write(2'd2, 32'h0);

    // R5 control register keeps only bits 7 and 10
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); check("R5 ctrl readback", rd, 32'h480);
    bus_write(2'd1, 32'h0);

    // R7 write-one-to-clear
    bus_write(2'd3, 32'h1FFF);
    pulse_evt(13'h0003);
    bus_write(2'd3, 32'h0001);
    bus_read(2'd3, rd); check("R7 partial clear", rd, 32'h2);
    check("R7 irq remains", cpu_irq, 1);
    bus_write(2'd3, 32'h0002);
    check("R7 irq cleared", cpu_irq, 0);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h0004; evt_set = 13'h0004;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt_set = '0;
    bus_read(2'd3, rd); check("R8 set wins", rd, 32'h4);
    bus_write(2'd3, 32'h1FFF);

    // R10 stop
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, rd); check("R10 stop clk_en", rd, 32'h0);
    bus_read(2'd3, rd); check("R10 stop clk-off", rd, 32'h10);

    // R9 start, no command pending
    bus_write(2'd0, 32'h2);
    bus_read(2'd0, rd); check("R9 start clk_en", rd, 32'h100);
    bus_read(2'd3, rd); check("R9 start clears clk-off", rd, 32'h0);
    check("R11 no launch without pending", cmd_launch, 0);

    // R10 both bits: stop wins
    bus_write(2'd0, 32'h3);
    check("R10 both clk_en", clk_en, 0);
    bus_read(2'd3, rd); check("R10 both clk-off", rd, 32'h10);

    // R11 launch pulse
    cmd_pending = 1'b1;
    bus_write(2'd0, 32'h2);
    check("R11 launch high", cmd_launch, 1);
    @(negedge clk);
    check("R11 launch one cycle", cmd_launch, 0);
    bus_write(2'd1, 32'h400);
    bus_write(2'd0, 32'h2);
    check("R11 stop-transfer blocks launch", cmd_launch, 0);
    cmd_pending = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule